// File: doc/BRIEF.md
# Programmable-Probability Bernoulli Bit Generator

This block emits one pseudo-random bit per clock whose chance of being 1 is chosen at run time. A threshold input sets that chance. A maximal-length shift-register sequence is advanced by a whole word's worth of steps in every enabled cycle. Each cycle therefore compares a fully renewed uniform word against the threshold, and never a copy of the previous word shifted by one place. The output is 1 when the word is below the threshold, which gives a probability of threshold / 2^WORD_W.

The next state is computed in one cycle by combinational logic that unrolls the single-step recurrence, so no result takes more than one clock. A seed port lets software-independent logic restart the sequence from a chosen point. An all-zero seed would lock the register, so it is replaced by a fixed nonzero constant. Several copies can run side by side with different seeds.

Top module: `bernoulli_gen`

## Requirements
- R1: While rst_n is low and after its release, bit_out and bit_valid are 0 and the internal word equals RESET_SEED (default 20'hB3C2D) until the first load or advance.
- R2: One sequence step maps word s to {s[W-2:0], ^(s & TAPS)}, with TAPS default 20'h90000 (feedback from bits 19 and 16). Each cycle with en high and seed_load low applies STEPS such steps, default 20.
- R3: In each cycle with en high, bit_out is registered as 1 exactly when the word held before that edge is unsigned-less-than thresh. A threshold of 0 therefore always yields 0, and a threshold equal to the word yields 0.
- R4: bit_valid is en delayed by one clock.
- R5: When en and seed_load are both low, the word and bit_out keep their values and bit_valid is 0.
- R6: seed_load has priority over en. The word takes seed on the next edge, or ZERO_SUB (default 20'h5A5A5) when seed is all zeros.
- R7: Over 8000 enabled cycles, the count of ones stays within a tolerance of 8000 * thresh / 2^20 for thresholds giving roughly 0.001, 0.037, 0.25 and 0.5. It is exactly 0 for threshold 0 and at least 7999 for threshold 20'hFFFFF.
- R8: The word is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Advance the sequence and produce a new output bit |
| seed_load | input | 1 | Load seed into the sequence register |
| seed | input | WORD_W | Seed value (zero is substituted) |
| thresh | input | WORD_W | Probability threshold; p = thresh / 2^WORD_W |
| bit_out | output | 1 | Registered Bernoulli bit |
| bit_valid | output | 1 | High one cycle after an enabled cycle |

## Verification
The bench builds the block with its defaults: a 20-bit word, 20 steps per cycle and the two-tap feedback. This makes a 0.037 probability expressible as a threshold near 38797, and the sequence period is long enough that 8000-cycle counting windows never repeat a word. With the full-width leap, every compared word is disjoint from the last one. The bench keeps its own model of the recurrence and matches every output bit exactly. It also measures the rate of ones per threshold, including the all-zero and all-ones extremes.

// File: rtl/bern_pkg.sv
package bern_pkg;
   localparam int          BERN_DEF_WORD_W     = 20;
   localparam logic [19:0] BERN_DEF_TAPS       = 20'h90000;
   localparam logic [19:0] BERN_DEF_RESET_SEED = 20'hB3C2D;
   localparam logic [19:0] BERN_DEF_ZERO_SUB   = 20'h5A5A5;
endpackage

// File: rtl/bern_lfsr_leap.sv
module bern_lfsr_leap #(
   parameter int               W          = 20,
   parameter int               STEPS      = 20,
   parameter logic [W-1:0]     TAPS       = 20'h90000,
   parameter logic [W-1:0]     RESET_SEED = 20'hB3C2D,
   parameter logic [W-1:0]     ZERO_SUB   = 20'h5A5A5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   input  logic         load,
   input  logic [W-1:0] seed,
   output logic [W-1:0] word
);
   logic [W-1:0] word_next;
   logic [W-1:0] seed_fixed;

   generate
      if (STEPS == 1) begin : g_single
         always_comb word_next = {word[W-2:0], ^(word & TAPS)};
      end else begin : g_leap
         always_comb begin
            logic [W-1:0] s;
            s = word;
            for (int k = 0; k < STEPS; k++) begin
               s = {s[W-2:0], ^(s & TAPS)};
            end
            word_next = s;
         end
      end
   endgenerate

   assign seed_fixed = (seed == '0) ? ZERO_SUB : seed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word <= RESET_SEED;
      else if (load)    word <= seed_fixed;
      else if (advance) word <= word_next;
   end
endmodule

// File: rtl/bern_cmp.sv
module bern_cmp #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] word,
   input  logic [W-1:0] thresh,
   output logic         bit_out,
   output logic         bit_valid
);
   logic below;
   assign below = (word < thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_out   <= 1'b0;
         bit_valid <= 1'b0;
      end else begin
         bit_valid <= en;
         if (en) bit_out <= below;
      end
   end
endmodule

// File: rtl/bernoulli_gen.sv
module bernoulli_gen
   import bern_pkg::*;
#(
   parameter int                  WORD_W     = BERN_DEF_WORD_W,
   parameter int                  STEPS      = BERN_DEF_WORD_W,
   parameter logic [WORD_W-1:0]   TAPS       = BERN_DEF_TAPS,
   parameter logic [WORD_W-1:0]   RESET_SEED = BERN_DEF_RESET_SEED,
   parameter logic [WORD_W-1:0]   ZERO_SUB   = BERN_DEF_ZERO_SUB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              seed_load,
   input  logic [WORD_W-1:0] seed,
   input  logic [WORD_W-1:0] thresh,
   output logic              bit_out,
   output logic              bit_valid
);
   localparam int TOP_BIT = WORD_W - 1;

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("WORD_W must be at least 2");
      end
      if (STEPS < 1) begin : g_bad_steps
         $error("STEPS must be at least 1");
      end
      if (TAPS[TOP_BIT] != 1'b1) begin : g_bad_taps
         $error("TAPS must include the top bit");
      end
      if (RESET_SEED == '0 || ZERO_SUB == '0) begin : g_bad_seed
         $error("RESET_SEED and ZERO_SUB must be nonzero");
      end
   endgenerate

   logic [WORD_W-1:0] lfsr_word;

   bern_lfsr_leap #(
      .W(WORD_W), .STEPS(STEPS), .TAPS(TAPS),
      .RESET_SEED(RESET_SEED), .ZERO_SUB(ZERO_SUB)
   ) u_lfsr (
      .clk(clk), .rst_n(rst_n), .advance(en), .load(seed_load),
      .seed(seed), .word(lfsr_word)
   );

   bern_cmp #(.W(WORD_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .en(en), .word(lfsr_word),
      .thresh(thresh), .bit_out(bit_out), .bit_valid(bit_valid)
   );
endmodule

// File: rtl/bernoulli_gen_chk.sv
module bernoulli_gen_chk #(
   parameter int                W        = 20,
   parameter logic [W-1:0]      ZERO_SUB = 20'h5A5A5
) (
   input logic         clk,
   input logic         rst_n,
   input logic         en,
   input logic         seed_load,
   input logic [W-1:0] seed,
   input logic [W-1:0] thresh,
   input logic [W-1:0] lfsr_word,
   input logic         bit_out,
   input logic         bit_valid
);
   always @(posedge clk) if (!rst_n) AST_RESET_OUT: assert (!bit_out && !bit_valid); // R1

   AST_VALID_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n) en |=> bit_valid); // R4
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !bit_valid); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !seed_load) |=> ($stable(lfsr_word) && $stable(bit_out))); // R5
   AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_load && seed != '0) |=> (lfsr_word == $past(seed))); // R6
   AST_ZERO_SEED_SUB: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_load && seed == '0) |=> (lfsr_word == ZERO_SUB)); // R6
   AST_ZERO_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (en && thresh == '0) |=> !bit_out); // R3
   AST_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (bit_out == ($past(lfsr_word) < $past(thresh)))); // R3
   AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) lfsr_word != '0); // R8
endmodule

bind bernoulli_gen bernoulli_gen_chk #(.W(WORD_W), .ZERO_SUB(ZERO_SUB)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load), .seed(seed),
   .thresh(thresh), .lfsr_word(lfsr_word), .bit_out(bit_out), .bit_valid(bit_valid)
);

// File: tb/bernoulli_gen_tb.sv
module bernoulli_gen_tb;
   localparam int          CLK_P  = 10;
   localparam int          W      = 20;
   localparam int          STEPS  = 20;
   localparam logic [19:0] TAPS   = 20'h90000;
   localparam logic [19:0] RSEED  = 20'hB3C2D;
   localparam logic [19:0] ZSUB   = 20'h5A5A5;
   localparam int          NCYC   = 8000;
   localparam int          NVEC   = 6;
   localparam int          VT [NVEC] = '{0, 1049, 38797, 262144, 524288, 1048575};
   localparam int          VLO[NVEC] = '{0, 0,    220,   1800,   3780,   7999};
   localparam int          VHI[NVEC] = '{0, 24,   375,   2200,   4220,   8000};

   logic clk = 0, rst_n = 0, en = 0, seed_load = 0;
   logic [W-1:0] seed = '0, thresh = '0;
   logic bit_out, bit_valid;

   int checks = 0, errors = 0;
   logic [W-1:0] m_word = RSEED;
   logic m_bit = 0, m_valid = 0;

   bernoulli_gen u_dut (.clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load),
      .seed(seed), .thresh(thresh), .bit_out(bit_out), .bit_valid(bit_valid));

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [W-1:0] leap(input logic [W-1:0] s0);
      logic [W-1:0] s = s0;
      for (int k = 0; k < STEPS; k++) s = {s[W-2:0], ^(s & TAPS)};
      return s;
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one clock: model follows R2/R3/R4/R5/R6, then sample at negedge
   task automatic cyc();
      @(posedge clk);
      if (en) m_bit = (m_word < thresh);
      m_valid = en;
      if (seed_load) m_word = (seed == '0) ? ZSUB : seed;
      else if (en)   m_word = leap(m_word);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int ones, mism;
      repeat (3) @(negedge clk);
      check(bit_out == 0, "R1 bit_out in reset", bit_out, 0);
      check(bit_valid == 0, "R1 bit_valid in reset", bit_valid, 0);
      rst_n = 1;
      cyc();
      check(bit_valid == 0 && bit_out == 0, "R1 idle after reset", {bit_valid, bit_out}, 0);

      // R1: first enabled compare uses RESET_SEED
      en = 1; thresh = RSEED + 1;
      cyc();
      check(bit_out == 1, "R1 reset word below RSEED+1", bit_out, 1);
      check(bit_valid == 1, "R4 valid one cycle after en", bit_valid, 1);

      // Table walk: exact bit match (R2, R3) and rate (R7)
      for (int i = 0; i < NVEC; i++) begin
         thresh = VT[i]; ones = 0; mism = 0;
         for (int c = 0; c < NCYC; c++) begin
            cyc();
            if (bit_out) ones++;
            if (bit_out !== m_bit || bit_valid !== m_valid) mism++;
         end
         check(mism == 0, $sformatf("R2 R3 exact bits thresh=%0d", VT[i]), mism, 0);
         check(ones >= VLO[i] && ones <= VHI[i], $sformatf("R7 ones thresh=%0d", VT[i]),
               ones, (longint'(NCYC) * VT[i]) >>> W);
      end

      // R3 strict compare, R6 seed priority over en
      seed_load = 1; seed = 20'h12345; en = 1; cyc();
      seed_load = 0; thresh = 20'h12346; cyc();
      check(bit_out == 1, "R6 seed loaded, R3 word<thresh", bit_out, 1);
      seed_load = 1; cyc();
      seed_load = 0; thresh = 20'h12345; cyc();
      check(bit_out == 0, "R3 word==thresh gives 0", bit_out, 0);

      // R6 zero seed substitution
      seed_load = 1; seed = '0; cyc();
      seed_load = 0; thresh = ZSUB + 1; cyc();
      check(bit_out == 1, "R6 zero seed -> ZSUB (below)", bit_out, 1);
      seed_load = 1; cyc();
      seed_load = 0; thresh = ZSUB; cyc();
      check(bit_out == 0, "R6 zero seed -> ZSUB (equal)", bit_out, 0);

      // R5 idle hold: load seed, hold en low, word must not advance
      en = 0; seed_load = 1; seed = 20'h00777; cyc();
      seed_load = 0; thresh = '0;
      cyc();
      check(bit_valid == 0, "R4 valid low after en low", bit_valid, 1'b0);
      repeat (5) cyc();
      check(bit_out == m_bit && bit_valid == 0, "R5 bit held while idle", bit_out, m_bit);
      en = 1; thresh = 20'h00778; cyc();
      check(bit_out == 1, "R5 word held while idle", bit_out, 1);
      thresh = '0; cyc();
      check(bit_out == 0, "R3 zero threshold", bit_out, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule